// File: doc/BRIEF.md
# Multi-Context Page Mapper

This block sits between a CPU with a 16-bit logical address bus and a 21-bit physical memory system. The logical space is cut into eight 8 KB windows; the top three address bits pick a window, and that window's 8-bit block number is joined with the low thirteen address bits to form the physical address. Four complete window tables are held at once. Only one of them translates at any moment, so software can switch between whole memory layouts with a single register write.

A control byte at logical address 0 picks the translating table, separately picks the table that software may edit, and carries an edit-enable bit. While editing is enabled, the eight logical bytes 0x0008 to 0x000F become the window registers of the edit table and can be read and written. While editing is disabled, those bytes are ordinary memory and the mapper leaves them alone. Whenever the mapper itself answers an access it raises a claim flag so external memory stays idle, and for every other access it raises a memory request together with the physical address and a region code for the block.

Top module: `ctx_page_mapper`

## Requirements
- R1: The physical address is the block number of window cpu_addr[15:13] in the translating table in bits 20:13, followed by cpu_addr[12:0] in bits 12:0.
- R2: After reset the control byte reads 0x00 and, in all four tables, window i holds block i.
- R3: Control bits 1:0 pick the translating table; a write that changes them alters translation from the following cycle on, and the cycle of the write itself still translates with the old table.
- R4: Control bits 5:4 pick the edit table and bit 7 enables editing; with bit 7 set, a write to 0x0008+i stores into window i of the edit table and a read there returns it, other tables being untouched.
- R5: With control bit 7 clear, accesses to 0x0008 to 0x000F are not claimed, are passed on as memory requests, and leave every window register unchanged.
- R6: Any access to address 0 is claimed whatever the edit state, and reading it returns bits 7, 5:4 and 1:0 as last written with bits 6, 3 and 2 reading 0.
- R7: The region output is 0 (RAM) for blocks 0x00 to 0x3F, 1 (flash) for 0x40 to 0x7F, 2 (expansion) for 0x80 to 0x9F and 3 (reserved) for 0xA0 to 0xFF.
- R8: With neither cpu_rd nor cpu_wr high, claim and mem_req are both 0; claim and mem_req are never high together, and every unclaimed access raises mem_req.
- R9: Editing a table that is not translating has no effect on the physical address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cpu_addr | input | 16 | Logical address of the current access |
| cpu_rd | input | 1 | Read access this cycle |
| cpu_wr | input | 1 | Write access this cycle |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data for claimed reads, 0 otherwise |
| claim | output | 1 | The mapper services this access |
| mem_req | output | 1 | External memory must service this access |
| phys_addr | output | 21 | Translated physical address |
| region | output | 2 | Region code of the translated block |

## Verification
The case that needs care is a control write that switches the translating table, since in that one cycle the new selector is being stored while translation of the same access is still being produced. The bench programs window 0 of table 2 with a distinct block, makes table 2 active, then writes the control byte at address 0 to select table 0 and samples the physical address inside that write cycle, expecting the table-2 block, and again on the very next access, expecting block 0. A second overlap, a write to a window address while editing is off, is judged by seeing the access go to memory in its own cycle and by reading the window back unchanged once editing is switched on.

// File: rtl/ctx_map_pkg.sv
// Shared sizes, field positions and region codes for the page mapper.
// Assumes 8-bit control byte with fixed field positions that software decodes.
package ctx_map_pkg;
    localparam int CPU_AW     = 16;
    localparam int OFFSET_W   = 13;
    localparam int BLOCK_W    = 8;
    localparam int PHYS_AW    = BLOCK_W + OFFSET_W;
    localparam int SLOT_COUNT = 1 << (CPU_AW - OFFSET_W);
    localparam int SLOT_W     = CPU_AW - OFFSET_W;
    localparam int SET_COUNT  = 4;
    localparam int SET_W      = $clog2(SET_COUNT);

    // Control byte field positions
    localparam int ACT_LSB  = 0;
    localparam int EDIT_LSB = 4;
    localparam int EN_BIT   = 7;

    // Register addresses
    localparam int CTL_ADDR  = 0;
    localparam int SLOT_BASE = 8;

    // Region boundaries (first block of each region)
    localparam int FLASH_FIRST = 8'h40;
    localparam int EXP_FIRST   = 8'h80;
    localparam int RSVD_FIRST  = 8'hA0;

    typedef enum logic [1:0] {
        RGN_RAM   = 2'd0,
        RGN_FLASH = 2'd1,
        RGN_EXP   = 2'd2,
        RGN_RSVD  = 2'd3
    } region_e;
endpackage

// File: rtl/map_ctl_reg.sv
// Control register: translating-table selector, edit-table selector, edit enable.
// Assumes the caller qualifies wr_en with an access to the control address.
module map_ctl_reg
    import ctx_map_pkg::*;
#(
    parameter int SW = SET_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [SW-1:0] wr_act,
    input  logic [SW-1:0] wr_edit,
    input  logic          wr_on,
    output logic [SW-1:0] act_set,
    output logic [SW-1:0] edit_set,
    output logic          edit_on,
    output logic [7:0]    rd_value
);
    // Holds the three control fields; cleared by reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_set  <= '0;
            edit_set <= '0;
            edit_on  <= 1'b0;
        end else if (wr_en) begin
            act_set  <= wr_act;
            edit_set <= wr_edit;
            edit_on  <= wr_on;
        end
    end

    // Packs the fields back into the byte layout, unused bits zero
    always_comb begin
        rd_value                     = '0;
        rd_value[ACT_LSB +: SW]      = act_set;
        rd_value[EDIT_LSB +: SW]     = edit_set;
        rd_value[EN_BIT]             = edit_on;
    end
endmodule

// File: rtl/map_slot_file.sv
// Window tables: NSETS tables of NSLOTS block-number registers each.
// One write port addressed by (set, slot); a translate read port and an edit
// read port. Reset loads window i of every table with block i.
module map_slot_file
    import ctx_map_pkg::*;
#(
    parameter int NSETS  = SET_COUNT,
    parameter int NSLOTS = SLOT_COUNT,
    parameter int BW     = BLOCK_W,
    localparam int SETW  = $clog2(NSETS),
    localparam int SLW   = $clog2(NSLOTS)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we,
    input  logic [SETW-1:0] w_set,
    input  logic [SLW-1:0]  w_slot,
    input  logic [BW-1:0]   w_data,
    input  logic [SETW-1:0] x_set,
    input  logic [SLW-1:0]  x_slot,
    output logic [BW-1:0]   x_block,
    input  logic [SETW-1:0] e_set,
    input  logic [SLW-1:0]  e_slot,
    output logic [BW-1:0]   e_block
);
    logic [BW-1:0] tbl [NSETS][NSLOTS];

    for (genvar s = 0; s < NSETS; s++) begin : g_set
        for (genvar k = 0; k < NSLOTS; k++) begin : g_slot
            // One window register with its identity reset value
            always_ff @(posedge clk) begin
                if (!rst_n)
                    tbl[s][k] <= BW'(k);
                else if (we && w_set == SETW'(s) && w_slot == SLW'(k))
                    tbl[s][k] <= w_data;
            end
        end
    end

    // Translate and edit read muxes
    assign x_block = tbl[x_set][x_slot];
    assign e_block = tbl[e_set][e_slot];
endmodule

// File: rtl/map_region_dec.sv
// Classifies a block number into RAM, flash, expansion or reserved.
// Assumes ascending region boundaries.
module map_region_dec
    import ctx_map_pkg::*;
#(
    parameter int BW = BLOCK_W
) (
    input  logic [BW-1:0] block,
    output region_e       rgn
);
    // Boundary compare, highest region first
    always_comb begin
        if (block >= BW'(RSVD_FIRST))
            rgn = RGN_RSVD;
        else if (block >= BW'(EXP_FIRST))
            rgn = RGN_EXP;
        else if (block >= BW'(FLASH_FIRST))
            rgn = RGN_FLASH;
        else
            rgn = RGN_RAM;
    end
endmodule

// File: rtl/ctx_page_mapper.sv
// Top of the page mapper: decodes register hits, routes writes to the control
// register or the window tables, translates every access and flags whether
// the mapper or external memory services it. Assumes cpu_rd and cpu_wr are
// not both high; a write takes precedence for register updates.
module ctx_page_mapper
    import ctx_map_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [CPU_AW-1:0]  cpu_addr,
    input  logic               cpu_rd,
    input  logic               cpu_wr,
    input  logic [7:0]         cpu_wdata,
    output logic [7:0]         cpu_rdata,
    output logic               claim,
    output logic               mem_req,
    output logic [PHYS_AW-1:0] phys_addr,
    output logic [1:0]         region
);
    logic [SET_W-1:0]   act_set, edit_set;
    logic               edit_on;
    logic [7:0]         ctl_value;
    logic [CPU_AW-1:0]  slot_off;
    logic               ctl_hit, slot_hit, access;
    logic [SLOT_W-1:0]  reg_idx;
    logic [BLOCK_W-1:0] x_block, e_block;
    region_e            rgn;

    // Register hit decode
    always_comb begin
        access   = cpu_rd | cpu_wr;
        slot_off = cpu_addr - CPU_AW'(SLOT_BASE);
        reg_idx  = slot_off[SLOT_W-1:0];
        ctl_hit  = (cpu_addr == CPU_AW'(CTL_ADDR));
        slot_hit = edit_on && (slot_off < CPU_AW'(SLOT_COUNT));
    end

    map_ctl_reg u_ctl (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (cpu_wr && ctl_hit),
        .wr_act   (cpu_wdata[ACT_LSB +: SET_W]),
        .wr_edit  (cpu_wdata[EDIT_LSB +: SET_W]),
        .wr_on    (cpu_wdata[EN_BIT]),
        .act_set  (act_set),
        .edit_set (edit_set),
        .edit_on  (edit_on),
        .rd_value (ctl_value)
    );

    map_slot_file u_slots (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (cpu_wr && slot_hit),
        .w_set   (edit_set),
        .w_slot  (reg_idx),
        .w_data  (cpu_wdata),
        .x_set   (act_set),
        .x_slot  (cpu_addr[CPU_AW-1:OFFSET_W]),
        .x_block (x_block),
        .e_set   (edit_set),
        .e_slot  (reg_idx),
        .e_block (e_block)
    );

    map_region_dec u_rgn (
        .block (x_block),
        .rgn   (rgn)
    );

    // Translation and region outputs
    assign phys_addr = {x_block, cpu_addr[OFFSET_W-1:0]};
    assign region    = rgn;

    // Service flags and read data
    always_comb begin
        claim     = access && (ctl_hit || slot_hit);
        mem_req   = access && !(ctl_hit || slot_hit);
        cpu_rdata = '0;
        if (cpu_rd && ctl_hit)
            cpu_rdata = ctl_value;
        else if (cpu_rd && slot_hit)
            cpu_rdata = e_block;
    end
endmodule

// File: rtl/ctx_page_mapper_chk.sv
// Property checker for the page mapper, attached by bind below.
module ctx_page_mapper_chk
    import ctx_map_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic [CPU_AW-1:0]  cpu_addr,
    input logic               cpu_rd,
    input logic               cpu_wr,
    input logic [7:0]         cpu_wdata,
    input logic [7:0]         cpu_rdata,
    input logic               claim,
    input logic               mem_req,
    input logic [PHYS_AW-1:0] phys_addr,
    input logic [1:0]         region
);
    logic armed;

    // Marks cycles whose previous cycle was out of reset
    always_ff @(posedge clk) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    p_xlate_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        armed && !$past(cpu_wr) && $stable(cpu_addr) |-> $stable(phys_addr));

    p_ctl_claim_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_rd || cpu_wr) && cpu_addr == 16'h0000 |-> claim);

    p_ctl_pad_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_rd && !cpu_wr && cpu_addr == 16'h0000 |->
            cpu_rdata[6] == 1'b0 && cpu_rdata[3:2] == 2'b00);

    p_ctl_readback_r4: assert property (@(posedge clk) disable iff (!rst_n)
        armed && $past(cpu_wr && cpu_addr == 16'h0000) &&
        cpu_rd && !cpu_wr && cpu_addr == 16'h0000 |->
            cpu_rdata[7] == $past(cpu_wdata[7]) &&
            cpu_rdata[5:4] == $past(cpu_wdata[5:4]) &&
            cpu_rdata[1:0] == $past(cpu_wdata[1:0]));

    p_edit_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
        armed && $past(cpu_wr && cpu_addr == 16'h0000 && !cpu_wdata[7]) &&
        (cpu_rd || cpu_wr) && cpu_addr == 16'h0008 |-> !claim && mem_req);

    p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_rd && !cpu_wr |-> !claim && !mem_req);

    p_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(claim && mem_req));

    p_served_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_rd || cpu_wr) && !claim |-> mem_req);

    p_region_ram_r7: assert property (@(posedge clk) disable iff (!rst_n)
        phys_addr[20:13] < 8'h40 |-> region == 2'd0);

    p_region_rsvd_r7: assert property (@(posedge clk) disable iff (!rst_n)
        phys_addr[20:13] >= 8'hA0 |-> region == 2'd3);

    p_region_exp_r7: assert property (@(posedge clk) disable iff (!rst_n)
        phys_addr[20:13] >= 8'h80 && phys_addr[20:13] < 8'hA0 |-> region == 2'd2);
endmodule

bind ctx_page_mapper ctx_page_mapper_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_addr  (cpu_addr),
    .cpu_rd    (cpu_rd),
    .cpu_wr    (cpu_wr),
    .cpu_wdata (cpu_wdata),
    .cpu_rdata (cpu_rdata),
    .claim     (claim),
    .mem_req   (mem_req),
    .phys_addr (phys_addr),
    .region    (region)
);

// File: tb/sim_ctx_page_mapper.sv
module sim_ctx_page_mapper;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic        cpu_rd = 1'b0;
    logic        cpu_wr = 1'b0;
    logic [7:0]  cpu_wdata = '0;
    logic [7:0]  cpu_rdata;
    logic        claim, mem_req;
    logic [20:0] phys_addr;
    logic [1:0]  region;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    ctx_page_mapper u0 (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_rd(cpu_rd),
        .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .claim(claim), .mem_req(mem_req), .phys_addr(phys_addr), .region(region)
    );

    task automatic check(input bit ok, input string tag,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cpu_write(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1; cpu_rd = 1'b0;
        @(negedge clk);
        cpu_wr = 1'b0;
    endtask

    // Reads and leaves outputs sampled mid-cycle
    task automatic cpu_read(input logic [15:0] a);
        @(negedge clk);
        cpu_addr = a; cpu_rd = 1'b1; cpu_wr = 1'b0;
        #2;
    endtask

    task automatic t_reset;
        cpu_read(16'h0000);
        check(claim == 1'b1, "R6 ctl claimed", 32'(claim), 1);
        check(cpu_rdata == 8'h00, "R2 ctl reset", 32'(cpu_rdata), 0);
        for (int i = 0; i < 8; i++) begin
            cpu_read({3'(i), 13'h0123});
            check(phys_addr == {8'(i), 13'h0123}, "R1 R2 identity",
                  32'(phys_addr), 32'({8'(i), 13'h0123}));
            check(mem_req == 1'b1 && claim == 1'b0, "R8 memory access",
                  32'({claim, mem_req}), 1);
            check(region == 2'd0, "R7 ram", 32'(region), 0);
        end
        cpu_write(16'h0000, 8'h03);
        cpu_read(16'hE456);
        check(phys_addr == {8'h07, 13'h0456}, "R2 table3 identity",
              32'(phys_addr), 32'({8'h07, 13'h0456}));
        cpu_write(16'h0000, 8'h00);
    endtask

    task automatic t_ctl_readback;
        cpu_write(16'h0000, 8'hFF);
        cpu_read(16'h0000);
        check(cpu_rdata == 8'hB3, "R6 readback", 32'(cpu_rdata), 32'h0B3);
        cpu_write(16'h0000, 8'h00);
    endtask

    task automatic t_edit_other;
        cpu_write(16'h0000, 8'h90);
        cpu_write(16'h000D, 8'h47);
        cpu_read(16'h000D);
        check(claim == 1'b1 && cpu_rdata == 8'h47, "R4 slot readback",
              32'(cpu_rdata), 32'h47);
        cpu_read(16'hBABC);
        check(phys_addr == {8'h05, 13'h1ABC}, "R9 inactive edit",
              32'(phys_addr), 32'({8'h05, 13'h1ABC}));
        cpu_write(16'h0000, 8'h80);
        cpu_read(16'h000D);
        check(cpu_rdata == 8'h05, "R4 other table untouched", 32'(cpu_rdata), 5);
        cpu_write(16'h0000, 8'h01);
        cpu_read(16'hBABC);
        check(phys_addr == {8'h47, 13'h1ABC}, "R3 active switch",
              32'(phys_addr), 32'({8'h47, 13'h1ABC}));
        check(region == 2'd1, "R7 flash", 32'(region), 1);
        cpu_read(16'h000D);
        check(claim == 1'b0 && mem_req == 1'b1, "R5 edit off passes",
              32'({claim, mem_req}), 1);
    endtask

    task automatic t_switch_same_cycle;
        cpu_write(16'h0000, 8'hA0);
        cpu_write(16'h0008, 8'h85);
        cpu_write(16'h0000, 8'h02);
        cpu_read(16'h0100);
        check(phys_addr == {8'h85, 13'h0100}, "R3 table2 active",
              32'(phys_addr), 32'({8'h85, 13'h0100}));
        @(negedge clk);
        cpu_rd = 1'b0; cpu_addr = 16'h0000; cpu_wdata = 8'h00; cpu_wr = 1'b1;
        #2;
        check(phys_addr[20:13] == 8'h85, "R3 old table in write cycle",
              32'(phys_addr[20:13]), 32'h85);
        @(negedge clk);
        cpu_wr = 1'b0; cpu_addr = 16'h0100; cpu_rd = 1'b1;
        #2;
        check(phys_addr[20:13] == 8'h00, "R3 new table next access",
              32'(phys_addr[20:13]), 0);
    endtask

    task automatic t_edit_disabled;
        @(negedge clk);
        cpu_rd = 1'b0; cpu_addr = 16'h0008; cpu_wdata = 8'hEE; cpu_wr = 1'b1;
        #2;
        check(claim == 1'b0 && mem_req == 1'b1, "R5 write not claimed",
              32'({claim, mem_req}), 1);
        @(negedge clk);
        cpu_wr = 1'b0;
        cpu_read(16'h0008);
        check(phys_addr == 21'h000008, "R5 translation unchanged",
              32'(phys_addr), 8);
        cpu_write(16'h0000, 8'h80);
        cpu_read(16'h0008);
        check(claim == 1'b1 && cpu_rdata == 8'h00, "R5 slot kept",
              32'(cpu_rdata), 0);
        cpu_write(16'h0000, 8'h00);
    endtask

    task automatic t_regions;
        logic [7:0] blk [7];
        logic [1:0] rg  [7];
        blk = '{8'h3F, 8'h40, 8'h7F, 8'h80, 8'h9F, 8'hA0, 8'hFF};
        rg  = '{2'd0, 2'd1, 2'd1, 2'd2, 2'd2, 2'd3, 2'd3};
        cpu_write(16'h0000, 8'hB0);
        for (int i = 0; i < 7; i++) cpu_write(16'(8 + i), blk[i]);
        cpu_write(16'h0000, 8'h03);
        for (int i = 0; i < 7; i++) begin
            cpu_read({3'(i), 13'h0010});
            check(phys_addr[20:13] == blk[i], "R1 programmed block",
                  32'(phys_addr[20:13]), 32'(blk[i]));
            check(region == rg[i], "R7 boundary", 32'(region), 32'(rg[i]));
        end
    endtask

    task automatic t_idle;
        @(negedge clk);
        cpu_rd = 1'b0; cpu_wr = 1'b0; cpu_addr = 16'h0000;
        #2;
        check(claim == 1'b0 && mem_req == 1'b0, "R8 idle",
              32'({claim, mem_req}), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_ctl_readback();
        t_edit_other();
        t_switch_same_cycle();
        t_edit_disabled();
        t_regions();
        t_idle();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule